// File: doc/BRIEF.md
# Iterative Feistel Cipher Core with On-the-Fly Key Schedule

This core encrypts or decrypts one n-bit block of a small parametric Feistel cipher. It performs one complete round per clock cycle. Each half of the state holds nb = n/(2b) words of b bits. A round adds the round key to the right half word by word, with no carry between words. It then passes the sum through a 3-bit substitution layer taken across word triplets, rotates bits inside each word, and XORs the result with a word-rotated copy of the left half. The key pair evolves with a similar step in the same cycle. The block and the key are both loaded in parallel when `start` is seen. The result appears on `data_out` together with a one-cycle `done` pulse.

Both directions use the same key input. A decryption run rebuilds the round keys in reverse order from the original key. Running decryption on a ciphertext with the key that produced it returns the plaintext.

Top module: `feistel_loop_core`

## Requirements
- R1: While reset is held and right after it is released, `done` is 0 and `data_out` is all zeros.
- R2: The round function adds the key half to the right half word by word modulo 2^b. No carry crosses a word boundary.
- R3: The substitution layer maps the 3-bit values 0..7 to 0,5,6,7,4,3,1,2. For each bit j, the value is formed from words 3t (LSB), 3t+1 and 3t+2 of a half.
- R4: Within each word triplet, word 3t is rotated right by one bit, word 3t+1 is left as it is, and word 3t+2 is rotated left by one bit. The word rotation moves word i to index (i+1) mod nb. Decryption uses the reverse rotation.
- R5: The key step is KR' = KL ^ WordRot(BitRot(S(KR + c))) and KL' = KR, with c added to word 0 only. With h = floor(nr/2), c is i+1 after round i < h and 2h-i after round i >= h. The two key halves are swapped after the step that follows round h-1. Encryption uses KR as the round key in every round. Decryption uses KL, except in round h, where it uses KR.
- R6: `done` is high for exactly one cycle, nr clock edges after the edge that accepted `start`.
- R7: The port layout is: left half in the upper n/2 bits, KL in the upper key bits, word 0 in the least significant bits of each half. The output is {R_nr, L_nr}. Decrypting that output with the same key returns the original block.
- R8: A `start` that arrives during a run is ignored. The run and its result are unchanged.
- R9: `data_out` changes only on the edge that ends a run. Between runs it keeps its last value.
- R10: By default the round count is 3n/4 + 2(nb + b/2), made odd by adding one when it is even. For n = 96 and b = 8 this gives 93.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load block and key and begin a run when idle |
| decrypt | input | 1 | 1 selects decryption, 0 selects encryption |
| key_in | input | N | Key, KL in the upper half |
| data_in | input | N | Block, left half in the upper half |
| data_out | output | N | Result of the last completed run |
| done | output | 1 | One-cycle pulse when a run completes |

## Verification
The stimulus starts with an all-zero key and block. In that case only the key-schedule constants move the state, which exposes errors in the constant sequence and the middle swap. Blocks and keys made of all-ones words make every word addition overflow, so any carry leaking into the next word shows up. Random blocks and keys exercise the S-box slicing and both rotations in every direction. Each ciphertext is then decrypted, and the result must equal the original plaintext, which tests the reversed key order. A second `start` is issued in the middle of a run, and the bench times the `done` pulse and how long `data_out` is held.

// File: rtl/feistel_loop_core.sv
module feistel_loop_core #(
  parameter int N  = 96,
  parameter int B  = 8,
  parameter int NR = (3*N/4 + 2*(N/(2*B) + B/2)) | 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         decrypt,
  input  logic [N-1:0] key_in,
  input  logic [N-1:0] data_in,
  output logic [N-1:0] data_out,
  output logic         done
);
  localparam int HW = N / 2;
  localparam int NB = HW / B;
  localparam int NT = NB / 3;
  localparam int RW = $clog2(NR + 1);
  localparam int H  = NR / 2;

  function automatic logic [2:0] sb3(input logic [2:0] x);
    case (x)
      3'd0: sb3 = 3'd0;
      3'd1: sb3 = 3'd5;
      3'd2: sb3 = 3'd6;
      3'd3: sb3 = 3'd7;
      3'd4: sb3 = 3'd4;
      3'd5: sb3 = 3'd3;
      3'd6: sb3 = 3'd1;
      default: sb3 = 3'd2;
    endcase
  endfunction

  function automatic logic [HW-1:0] fmix(input logic [HW-1:0] x, input logic [HW-1:0] k);
    logic [HW-1:0] a, s, o;
    logic [2:0] t3;
    logic [B-1:0] w0, w2;
    for (int w = 0; w < NB; w++) a[w*B +: B] = x[w*B +: B] + k[w*B +: B];
    for (int t = 0; t < NT; t++)
      for (int j = 0; j < B; j++) begin
        t3 = sb3({a[(3*t+2)*B+j], a[(3*t+1)*B+j], a[3*t*B+j]});
        s[3*t*B+j]     = t3[0];
        s[(3*t+1)*B+j] = t3[1];
        s[(3*t+2)*B+j] = t3[2];
      end
    for (int t = 0; t < NT; t++) begin
      w0 = s[3*t*B +: B];
      w2 = s[(3*t+2)*B +: B];
      o[3*t*B +: B]     = {w0[0], w0[B-1:1]};
      o[(3*t+1)*B +: B] = s[(3*t+1)*B +: B];
      o[(3*t+2)*B +: B] = {w2[B-2:0], w2[B-1]};
    end
    return o;
  endfunction

  function automatic logic [HW-1:0] wrot(input logic [HW-1:0] x);
    logic [HW-1:0] o;
    for (int i = 0; i < NB; i++) o[((i+1)%NB)*B +: B] = x[i*B +: B];
    return o;
  endfunction

  function automatic logic [HW-1:0] wrot_inv(input logic [HW-1:0] x);
    logic [HW-1:0] o;
    for (int i = 0; i < NB; i++) o[i*B +: B] = x[((i+1)%NB)*B +: B];
    return o;
  endfunction

  logic [HW-1:0] lh, rh, kl, kr;
  logic [RW-1:0] rnd;
  logic          busy, dec_q;
  logic [N-1:0]  dout_q;

  logic [HW-1:0] rk, fr, n_l, n_r, fk, kn, n_kl, n_kr;
  logic [B-1:0]  kc;
  logic          last, mid;
  int            cv;

  assign last = (int'(rnd) == NR - 1);
  assign mid  = (int'(rnd) == H - 1);
  assign rk   = (!dec_q || int'(rnd) == H) ? kr : kl;
  assign fr   = fmix(rh, rk);
  assign n_l  = rh;
  assign n_r  = dec_q ? wrot_inv(lh ^ fr) : (wrot(lh) ^ fr);

  always_comb begin
    cv = (int'(rnd) < H) ? int'(rnd) + 1 : 2*H - int'(rnd);
    kc = cv[B-1:0];
  end

  assign fk   = fmix(kr, {{(HW-B){1'b0}}, kc});
  assign kn   = kl ^ wrot(fk);
  assign n_kl = mid ? kn : kr;
  assign n_kr = mid ? kr : kn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; dec_q <= 1'b0; rnd <= '0;
      lh <= '0; rh <= '0; kl <= '0; kr <= '0; dout_q <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        lh <= n_l; rh <= n_r; kl <= n_kl; kr <= n_kr;
        rnd <= rnd + 1'b1;
        if (last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          dout_q <= {n_r, n_l};
        end
      end else if (start) begin
        busy     <= 1'b1;
        rnd      <= '0;
        dec_q    <= decrypt;
        {lh, rh} <= data_in;
        {kl, kr} <= key_in;
      end
    end
  end

  assign data_out = dout_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy));
  // R8
  run_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && rnd == $past(rnd) + 1'b1));
  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && last) |=> $stable(data_out));
  // R10
  rnd_range_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> int'(rnd) < NR);
endmodule

// File: tb/feistel_loop_core_test.sv
module feistel_loop_core_test;
  localparam int N  = 96;
  localparam int B  = 8;
  localparam int HW = 48;
  localparam int NB = 6;
  localparam int NR = 93;
  localparam int H  = 46;

  logic clk = 0, rst_n = 0, start = 0, decrypt = 0;
  logic [N-1:0] key_in = '0, data_in = '0;
  logic [N-1:0] data_out;
  logic done;

  int checks = 0, fails = 0;
  bit finished = 0;

  feistel_loop_core uut (.clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
                         .key_in(key_in), .data_in(data_in), .data_out(data_out), .done(done));

  always #5 clk = ~clk;

  int sbt [8] = '{0, 5, 6, 7, 4, 3, 1, 2};

  function automatic int gw(input logic [HW-1:0] h, input int i);
    return int'(h[i*B +: B]);
  endfunction

  // R2 R3 R4 reference mixing, one word at a time with integers
  function automatic logic [HW-1:0] mix(input logic [HW-1:0] x, input logic [HW-1:0] k);
    int a[NB];
    int s[NB];
    logic [HW-1:0] o;
    int m = (1 << B) - 1;
    for (int i = 0; i < NB; i++) begin a[i] = (gw(x, i) + gw(k, i)) & m; s[i] = 0; end
    for (int t = 0; t < NB/3; t++)
      for (int j = 0; j < B; j++) begin
        int v = ((a[3*t] >> j) & 1) | (((a[3*t+1] >> j) & 1) << 1) | (((a[3*t+2] >> j) & 1) << 2);
        int y = sbt[v];
        for (int q = 0; q < 3; q++) s[3*t+q] = s[3*t+q] | (((y >> q) & 1) << j);
      end
    for (int t = 0; t < NB/3; t++) begin
      s[3*t]   = ((s[3*t] >> 1) | (s[3*t] << (B-1))) & m;
      s[3*t+2] = ((s[3*t+2] << 1) | (s[3*t+2] >> (B-1))) & m;
    end
    for (int i = 0; i < NB; i++) o[i*B +: B] = s[i][B-1:0];
    return o;
  endfunction

  function automatic logic [HW-1:0] rot_up(input logic [HW-1:0] x);
    return {x[HW-B-1:0], x[HW-1:HW-B]};
  endfunction

  function automatic logic [HW-1:0] rot_dn(input logic [HW-1:0] x);
    return {x[B-1:0], x[HW-1:B]};
  endfunction

  // R5 R7 full reference cipher
  function automatic logic [N-1:0] ref_cipher(input logic dc, input logic [N-1:0] k, input logic [N-1:0] d);
    logic [HW-1:0] l = d[N-1:HW], r = d[HW-1:0], kl = k[N-1:HW], kr = k[HW-1:0];
    logic [HW-1:0] rkey, f, nk, tmp;
    for (int i = 0; i < NR; i++) begin
      int c = (i < H) ? i + 1 : 2*H - i;
      rkey = (!dc || i == H) ? kr : kl;
      f = mix(r, rkey);
      tmp = dc ? rot_dn(l ^ f) : (rot_up(l) ^ f);
      l = r; r = tmp;
      nk = kl ^ rot_up(mix(kr, HW'(c)));
      kl = kr; kr = nk;
      if (i == H - 1) begin tmp = kl; kl = kr; kr = tmp; end
    end
    return {r, l};
  endfunction

  bit m_busy = 0, m_done = 0;
  int m_cnt = 0;
  logic [N-1:0] m_res = '0, m_out = '0;

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic st, input logic dc, input logic [N-1:0] k, input logic [N-1:0] d);
    start = st; decrypt = dc; key_in = k; data_in = d;
    @(posedge clk);
    if (m_busy) begin
      m_cnt++; m_done = 0;
      if (m_cnt == NR) begin m_busy = 0; m_done = 1; m_out = m_res; end
    end else begin
      m_done = 0;
      if (st) begin m_busy = 1; m_cnt = 0; m_res = ref_cipher(dc, k, d); end
    end
    @(negedge clk);
    // R6
    chk(done == m_done, "R6 done", N'(done), N'(m_done));
    // R2 R3 R4 R5 R9
    chk(data_out == m_out, "R2/R3/R4/R5/R9 data_out", data_out, m_out);
  endtask

  task automatic run(input logic dc, input logic [N-1:0] k, input logic [N-1:0] d,
                     output logic [N-1:0] res, output int lat);
    lat = 0;
    cyc(1, dc, k, d);
    do begin cyc(0, 0, '0, '0); lat++; end while (!done && lat < 200);
    res = data_out;
  endtask

  initial begin
    logic [N-1:0] ct, pt, back, k, first;
    int lat;
    repeat (3) @(negedge clk);
    // R1
    chk(done == 0 && data_out == '0, "R1 reset", data_out, '0);
    rst_n = 1;
    cyc(0, 0, '0, '0);
    chk(data_out == '0, "R1 after release", data_out, '0);

    run(0, '0, '0, ct, lat);
    // R10 R6 latency of nr = 93 edges
    chk(lat == NR, "R10 latency", N'(lat), N'(NR));
    run(1, '0, ct, back, lat);
    // R7
    chk(back == '0, "R7 zero roundtrip", back, '0);

    // R2 carries must stay inside words
    k = {N{1'b1}}; pt = {N{1'b1}};
    run(0, k, pt, ct, lat);
    run(1, k, ct, back, lat);
    chk(back == pt, "R7 ones roundtrip", back, pt);

    for (int n = 0; n < 4; n++) begin
      k  = {$urandom, $urandom, $urandom};
      pt = {$urandom, $urandom, $urandom};
      run(0, k, pt, ct, lat);
      chk(ct == ref_cipher(0, k, pt), "R3/R4/R5 random enc", ct, ref_cipher(0, k, pt));
      run(1, k, ct, back, lat);
      chk(back == pt, "R7 random roundtrip", back, pt);
    end

    // R8 start during a run is ignored
    k = 96'h0123456789abcdef01234567; pt = 96'hfedcba9876543210aa55aa55;
    first = ref_cipher(0, k, pt);
    cyc(1, 0, k, pt);
    repeat (10) cyc(0, 0, '0, '0);
    cyc(1, 1, ~k, ~pt);
    lat = 11;
    do begin cyc(0, 0, '0, '0); lat++; end while (!done && lat < 200);
    chk(data_out == first, "R8 ignored start", data_out, first);
    chk(lat == NR, "R8 run length", N'(lat), N'(NR));

    // R9 hold between runs
    repeat (20) cyc(0, 1, ~k, ~pt);
    chk(data_out == first, "R9 hold", data_out, first);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule